// File: doc/BRIEF.md
# Rename Group Dependency Checker with Tag Redundancy

This block sits in the rename stage of a four-wide out-of-order core. It receives one rename group per cycle. Each of the four slots carries a valid bit, two source architectural register tags and one destination architectural register tag. Slot 0 holds the oldest instruction. For each valid instruction, every source tag is compared with the destination tags of the valid older instructions in the group. The youngest matching producer is reported with a hit bit and a two-bit slot index.

When a group does not fill every slot, decode has already copied the valid instructions' tags into the tag fields of the empty slots. The comparators that serve those empty slots would otherwise be idle, so here they check each original tag against its copies.

- With one redundant copy, a mismatch is detected but not repaired.
- With three redundant copies (a lone instruction), a bitwise majority over the four values repairs a damaged tag.
- A two-against-two split on any bit is reported as uncorrectable.

Results are registered with one cycle of latency. There is no backpressure.

Top module: `rename_tag_guard`

## Requirements
- R1: A synchronous active-high reset clears every output to zero.
- R2: For each valid slot i and each source, the tag is compared with the destination tags of valid slots j < i. The hit bit is set when any of them matches, and the index (field bits [2i+1:2i]) names the largest matching j. Slot 0, empty slots and empty older slots never produce or take part in a hit.
- R3: With slot mask 4'b0011, slot 2 carries copies of slot 0's three tags and slot 3 carries copies of slot 1's. Any mismatch sets err_det for that original (bit 0 or bit 1). Tags are passed through unchanged and err_fix stays 0.
- R4: With slot mask 4'b0111, only slot 3's destination field is a copy, of slot 0's destination. A mismatch sets err_det[0]. Slot 3's source fields are ignored.
- R5: With slot mask 4'b0001, slots 1, 2 and 3 each carry a full copy of slot 0's tags. err_det[0] is set when any copy differs from the original. Each bit is voted over the four values and becomes 1 when at least three of them are 1. When the voted tags differ from the original and no tie exists, err_fix[0] is set and the voted tags are output.
- R6: With slot mask 4'b0001, if some bit of some field has exactly two ones among its four values, err_unfix is set and err_fix is 0. The original tags are output.
- R7: With slot mask 4'b1111, or any mask other than those in R3 to R5, no error checking takes place and all error flags are 0.
- R8: out_valid equals in_valid of the previous cycle. When in_valid was low, every other output is 0 in the following cycle.
- R9: Output tag fields and out_slot_vld are set only for valid slots; fields of empty slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group present this cycle |
| in_slot_vld | input | 4 | Per-slot valid, bit 0 oldest |
| in_src_a | input | 4*TAG_W | First source tags, slot i at [i*TAG_W +: TAG_W] |
| in_src_b | input | 4*TAG_W | Second source tags |
| in_dst | input | 4*TAG_W | Destination tags |
| out_valid | output | 1 | Registered group valid |
| out_slot_vld | output | 4 | Registered slot valid |
| out_src_a | output | 4*TAG_W | Checked first source tags |
| out_src_b | output | 4*TAG_W | Checked second source tags |
| out_dst | output | 4*TAG_W | Checked destination tags |
| dep_a_hit | output | 4 | First source has an in-group producer |
| dep_a_idx | output | 8 | Producer slot for first source, 2 bits per slot |
| dep_b_hit | output | 4 | Second source has an in-group producer |
| dep_b_idx | output | 8 | Producer slot for second source |
| err_det | output | 4 | Per-original-slot mismatch detected |
| err_fix | output | 4 | Per-original-slot tag repaired by vote |
| err_unfix | output | 1 | Vote tied on some bit |

## Verification
Dependency matching and error detection can both act on the same group. Groups of two and three instructions are therefore driven in which a younger source reads an older destination while a replicated tag is corrupted. The hit and index are judged to be exactly what a clean group would give, and the error flag rises only for the original whose copy was damaged. A masked group with a hole, where an invalid slot holds a matching destination, confirms that neither copies nor empty slots ever appear as producers.

// File: rtl/rename_tag_guard.sv
module rename_tag_guard #(
  parameter int TAG_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [3:0]           in_slot_vld,
  input  logic [4*TAG_W-1:0]   in_src_a,
  input  logic [4*TAG_W-1:0]   in_src_b,
  input  logic [4*TAG_W-1:0]   in_dst,
  output logic                 out_valid,
  output logic [3:0]           out_slot_vld,
  output logic [4*TAG_W-1:0]   out_src_a,
  output logic [4*TAG_W-1:0]   out_src_b,
  output logic [4*TAG_W-1:0]   out_dst,
  output logic [3:0]           dep_a_hit,
  output logic [7:0]           dep_a_idx,
  output logic [3:0]           dep_b_hit,
  output logic [7:0]           dep_b_idx,
  output logic [3:0]           err_det,
  output logic [3:0]           err_fix,
  output logic                 err_unfix
);
  localparam int SLOTS = 4;
  localparam int IDX_W = 2;
  localparam int GW    = SLOTS * TAG_W;

  logic [TAG_W-1:0] sa [SLOTS];
  logic [TAG_W-1:0] sb [SLOTS];
  logic [TAG_W-1:0] sd [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
    assign sa[g] = in_src_a[g*TAG_W +: TAG_W];
    assign sb[g] = in_src_b[g*TAG_W +: TAG_W];
    assign sd[g] = in_dst[g*TAG_W +: TAG_W];
  end

  function automatic logic [TAG_W:0] vote4(input logic [TAG_W-1:0] a, b, c, d);
    logic [2:0] cnt;
    logic [TAG_W:0] r;
    r = '0;
    for (int k = 0; k < TAG_W; k++) begin
      cnt = 3'(a[k]) + 3'(b[k]) + 3'(c[k]) + 3'(d[k]);
      r[k] = cnt >= 3'd3;
      if (cnt == 3'd2) r[TAG_W] = 1'b1;
    end
    return r;
  endfunction

  wire solo = in_slot_vld == 4'b0001;
  wire pair = in_slot_vld == 4'b0011;
  wire trio = in_slot_vld == 4'b0111;

  wire [TAG_W:0] va = vote4(sa[0], sa[1], sa[2], sa[3]);
  wire [TAG_W:0] vb = vote4(sb[0], sb[1], sb[2], sb[3]);
  wire [TAG_W:0] vd = vote4(sd[0], sd[1], sd[2], sd[3]);
  wire tie = va[TAG_W] | vb[TAG_W] | vd[TAG_W];

  wire solo_diff = (sa[1] != sa[0]) | (sa[2] != sa[0]) | (sa[3] != sa[0]) |
                   (sb[1] != sb[0]) | (sb[2] != sb[0]) | (sb[3] != sb[0]) |
                   (sd[1] != sd[0]) | (sd[2] != sd[0]) | (sd[3] != sd[0]);
  wire solo_fix  = !tie && ((va[TAG_W-1:0] != sa[0]) || (vb[TAG_W-1:0] != sb[0]) ||
                            (vd[TAG_W-1:0] != sd[0]));
  wire pair_d0   = {sa[2], sb[2], sd[2]} != {sa[0], sb[0], sd[0]};
  wire pair_d1   = {sa[3], sb[3], sd[3]} != {sa[1], sb[1], sd[1]};

  logic [3:0] det_c, fix_c, ha_c, hb_c;
  logic [7:0] ia_c, ib_c;
  logic [GW-1:0] oa_c, ob_c, od_c;

  always_comb begin
    det_c = '0;
    fix_c = '0;
    if (solo) begin
      det_c[0] = solo_diff;
      fix_c[0] = solo_fix;
    end else if (pair) begin
      det_c[1:0] = {pair_d1, pair_d0};
    end else if (trio) begin
      det_c[0] = sd[3] != sd[0];
    end
  end

  always_comb begin
    ha_c = '0; hb_c = '0; ia_c = '0; ib_c = '0;
    for (int i = 1; i < SLOTS; i++) begin
      for (int j = 0; j < i; j++) begin
        if (in_slot_vld[i] && in_slot_vld[j] && sa[i] == sd[j]) begin
          ha_c[i] = 1'b1;
          ia_c[i*IDX_W +: IDX_W] = IDX_W'(j);
        end
        if (in_slot_vld[i] && in_slot_vld[j] && sb[i] == sd[j]) begin
          hb_c[i] = 1'b1;
          ib_c[i*IDX_W +: IDX_W] = IDX_W'(j);
        end
      end
    end
  end

  always_comb begin
    oa_c = '0; ob_c = '0; od_c = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (in_slot_vld[i]) begin
        oa_c[i*TAG_W +: TAG_W] = sa[i];
        ob_c[i*TAG_W +: TAG_W] = sb[i];
        od_c[i*TAG_W +: TAG_W] = sd[i];
      end
    end
    if (solo && solo_fix) begin
      oa_c[TAG_W-1:0] = va[TAG_W-1:0];
      ob_c[TAG_W-1:0] = vb[TAG_W-1:0];
      od_c[TAG_W-1:0] = vd[TAG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid    <= 1'b0;
      out_slot_vld <= '0;
      out_src_a    <= '0;
      out_src_b    <= '0;
      out_dst      <= '0;
      dep_a_hit    <= '0;
      dep_a_idx    <= '0;
      dep_b_hit    <= '0;
      dep_b_idx    <= '0;
      err_det      <= '0;
      err_fix      <= '0;
      err_unfix    <= 1'b0;
    end else begin
      out_valid    <= 1'b1;
      out_slot_vld <= in_slot_vld;
      out_src_a    <= oa_c;
      out_src_b    <= ob_c;
      out_dst      <= od_c;
      dep_a_hit    <= ha_c;
      dep_a_idx    <= ia_c;
      dep_b_hit    <= hb_c;
      dep_b_idx    <= ib_c;
      err_det      <= det_c;
      err_fix      <= fix_c;
      err_unfix    <= solo && tie;
    end
  end
endmodule

// File: rtl/rename_tag_guard_chk.sv
module rename_tag_guard_chk #(
  parameter int TAG_W = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                out_valid,
  input logic [3:0]          out_slot_vld,
  input logic [3:0]          dep_a_hit,
  input logic [3:0]          dep_b_hit,
  input logic [3:0]          err_det,
  input logic [3:0]          err_fix,
  input logic                err_unfix
);
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_slot_vld == '0 && err_det == '0 && !err_unfix));

  assert_dep_valid_only_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((dep_a_hit | dep_b_hit) & ~out_slot_vld) == '0 && !dep_a_hit[0] && !dep_b_hit[0]));

  assert_fix_solo_only_R5: assert property (@(posedge clk) disable iff (rst)
    (err_fix != '0) |-> (err_det[0] && out_slot_vld == 4'b0001 && err_fix[3:1] == '0));

  assert_tie_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    err_unfix |-> (err_fix == '0 && err_det[0] && out_slot_vld == 4'b0001));

  assert_full_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (out_slot_vld == 4'b1111) |-> (err_det == '0 && !err_unfix));

  assert_trio_slot0_R4: assert property (@(posedge clk) disable iff (rst)
    (out_slot_vld == 4'b0111) |-> (err_det[3:1] == '0));

  assert_pair_no_fix_R3: assert property (@(posedge clk) disable iff (rst)
    (out_slot_vld == 4'b0011) |-> (err_fix == '0 && err_det[3:2] == '0));
endmodule

bind rename_tag_guard rename_tag_guard_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_slot_vld(out_slot_vld), .dep_a_hit(dep_a_hit), .dep_b_hit(dep_b_hit),
  .err_det(err_det), .err_fix(err_fix), .err_unfix(err_unfix)
);

// File: tb/tb_rename_tag_guard.sv
`timescale 1ns/100ps
module tb_rename_tag_guard;
  localparam int TAG_W = 5;
  localparam int GW = 4*TAG_W;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [3:0] in_slot_vld = '0;
  logic [GW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic out_valid, err_unfix;
  logic [3:0] out_slot_vld, dep_a_hit, dep_b_hit, err_det, err_fix;
  logic [7:0] dep_a_idx, dep_b_idx;
  logic [GW-1:0] out_src_a, out_src_b, out_dst;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rename_tag_guard #(.TAG_W(TAG_W)) dut (.*);

  function automatic logic [GW-1:0] pk(input int t0, t1, t2, t3);
    return {5'(t3), 5'(t2), 5'(t1), 5'(t0)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] m, input logic [GW-1:0] a, b, d);
    @(negedge clk);
    in_valid = v; in_slot_vld = m; in_src_a = a; in_src_b = b; in_dst = d;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    apply(1'b1, 4'b1111, pk(1,2,3,4), pk(5,6,7,8), pk(9,10,11,12));
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "out_dst", 32'(out_dst), 0);
    chk("R1", "dep_a_hit", 32'(dep_a_hit), 0);
    rst = 1'b0;
  endtask

  task automatic t_full_deps;
    apply(1'b1, 4'b1111, pk(3,3,7,3), pk(1,8,9,7), pk(3,7,3,9));
    chk("R8", "out_valid", 32'(out_valid), 1);
    chk("R2", "dep_a_hit", 32'(dep_a_hit), 32'b1110);
    chk("R2", "dep_a_idx", 32'(dep_a_idx), 32'b10_01_00_00);
    chk("R2", "dep_b_hit", 32'(dep_b_hit), 32'b1000);
    chk("R2", "dep_b_idx", 32'(dep_b_idx), 32'b01_00_00_00);
    chk("R7", "err_det", 32'(err_det), 0);
    chk("R9", "out_dst", 32'(out_dst), 32'(pk(3,7,3,9)));
  endtask

  task automatic t_full_noisy;
    apply(1'b1, 4'b1111, pk(1,2,3,4), pk(5,6,7,8), pk(9,10,11,12));
    chk("R7", "err_det full", 32'(err_det), 0);
    chk("R7", "err_unfix full", 32'(err_unfix), 0);
  endtask

  task automatic t_pair;
    apply(1'b1, 4'b0011, pk(4,6,4,6), pk(5,2,5,2), pk(6,1,6,1));
    chk("R3", "err_det clean", 32'(err_det), 0);
    chk("R2", "dep_a_hit pair", 32'(dep_a_hit), 32'b0010);
    chk("R9", "out_src_a pair", 32'(out_src_a), 32'(pk(4,6,0,0)));
    apply(1'b1, 4'b0011, pk(4,6,4,6), pk(5,2,5,3), pk(6,1,6,1));
    chk("R3", "err_det slot1", 32'(err_det), 32'b0010);
    chk("R3", "err_fix slot1", 32'(err_fix), 0);
    chk("R2", "dep_a_hit with error", 32'(dep_a_hit), 32'b0010);
    chk("R2", "dep_a_idx with error", 32'(dep_a_idx), 0);
    chk("R3", "out_src_b pass", 32'(out_src_b), 32'(pk(5,2,0,0)));
    apply(1'b1, 4'b0011, pk(4,6,4,6), pk(5,2,5,2), pk(6,1,7,1));
    chk("R3", "err_det slot0", 32'(err_det), 32'b0001);
  endtask

  task automatic t_trio;
    apply(1'b1, 4'b0111, pk(1,10,2,31), pk(3,4,10,31), pk(10,11,12,10));
    chk("R4", "err_det clean src ignored", 32'(err_det), 0);
    chk("R2", "dep_a_hit trio", 32'(dep_a_hit), 32'b0010);
    chk("R2", "dep_b_hit trio", 32'(dep_b_hit), 32'b0100);
    chk("R2", "dep_b_idx trio", 32'(dep_b_idx), 0);
    apply(1'b1, 4'b0111, pk(1,10,2,31), pk(3,4,10,31), pk(10,11,12,14));
    chk("R4", "err_det trio", 32'(err_det), 32'b0001);
    chk("R2", "dep_b_hit trio err", 32'(dep_b_hit), 32'b0100);
    chk("R9", "out_dst trio", 32'(out_dst), 32'(pk(10,11,12,0)));
  endtask

  task automatic t_solo;
    apply(1'b1, 4'b0001, pk(5,5,5,5), pk(12,12,12,12), pk(20,20,20,20));
    chk("R5", "err_det clean", 32'(err_det), 0);
    chk("R2", "dep hit solo", 32'(dep_a_hit | dep_b_hit), 0);
    apply(1'b1, 4'b0001, pk(5,5,5,5), pk(12,12,13,12), pk(20,20,20,20));
    chk("R5", "err_det copy", 32'(err_det), 1);
    chk("R5", "err_fix copy", 32'(err_fix), 0);
    chk("R5", "out_src_b copy", 32'(out_src_b), 32'(pk(12,0,0,0)));
    apply(1'b1, 4'b0001, pk(7,5,5,5), pk(12,12,12,12), pk(20,20,20,20));
    chk("R5", "err_det orig", 32'(err_det), 1);
    chk("R5", "err_fix orig", 32'(err_fix), 1);
    chk("R5", "out_src_a voted", 32'(out_src_a), 32'(pk(5,0,0,0)));
    chk("R6", "err_unfix none", 32'(err_unfix), 0);
    apply(1'b1, 4'b0001, pk(5,5,5,5), pk(12,12,12,12), pk(20,20,4,20));
    chk("R5", "err_fix dst copy", 32'(err_fix), 0);
    chk("R5", "out_dst kept", 32'(out_dst), 32'(pk(20,0,0,0)));
  endtask

  task automatic t_tie;
    apply(1'b1, 4'b0001, pk(5,5,4,4), pk(12,12,12,12), pk(20,20,20,20));
    chk("R6", "err_unfix", 32'(err_unfix), 1);
    chk("R6", "err_fix", 32'(err_fix), 0);
    chk("R6", "err_det", 32'(err_det), 1);
    chk("R6", "out_src_a orig", 32'(out_src_a), 32'(pk(5,0,0,0)));
  endtask

  task automatic t_hole;
    apply(1'b1, 4'b0101, pk(0,9,3,0), pk(0,9,8,0), pk(3,3,7,3));
    chk("R2", "dep_a_hit hole", 32'(dep_a_hit), 32'b0100);
    chk("R2", "dep_a_idx hole", 32'(dep_a_idx), 0);
    chk("R7", "err_det hole", 32'(err_det), 0);
    chk("R9", "out_slot_vld hole", 32'(out_slot_vld), 32'b0101);
    chk("R9", "out_dst hole", 32'(out_dst), 32'(pk(3,0,7,0)));
  endtask

  task automatic t_idle;
    apply(1'b1, 4'b0011, pk(4,6,4,6), pk(5,2,5,3), pk(6,1,6,1));
    apply(1'b0, 4'b0011, pk(4,6,4,6), pk(5,2,5,3), pk(6,1,6,1));
    chk("R8", "out_valid idle", 32'(out_valid), 0);
    chk("R8", "err_det idle", 32'(err_det), 0);
    chk("R8", "dep_a_hit idle", 32'(dep_a_hit), 0);
    chk("R8", "out_src_a idle", 32'(out_src_a), 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full_deps();
    t_full_noisy();
    t_pair();
    t_trio();
    t_solo();
    t_tie();
    t_hole();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule